// File: doc/BRIEF.md
# Bridge Parity Error Handler

This block watches both sides of a two-port bus bridge for parity faults and turns them into the bridge's reactions. For every address or data phase it is told about, it forms the even parity of the 32-bit address/data lines and the 4-bit command/byte-enable lines. It compares that value with the parity bit, which arrives one clock after the phase. From the result it decides whether a secondary-side address is claimed, pulses the active-low error and system-error lines, and raises sticky status flags. Software-owned enable bits come in as plain inputs: one parity-response and one system-error enable from the primary command word, and one secondary parity-response enable from the bridge control word.

Three phase streams are checked in parallel: secondary address phases, secondary read-data phases of downstream reads, and data phases of Type 0 configuration writes aimed at the bridge from the primary side. Every reaction appears two clocks after the phase that caused it. This matches the usual timing of an error line on such a bus. Status flags follow one clock later and stay set until a write-one-to-clear pulse removes them. On a secondary read, the parity bit as received is handed on to the primary side unchanged, so that the original requester sees the fault itself.

Top module: `pbr_parity_guard`

## Requirements
- R1: A phase is in error when the parity bit sampled one clock after it differs from the XOR of all 32 address/data bits and all 4 command/byte-enable bits (even parity over the 37 bits).
- R2: When a secondary address phase with `s_hit`=1 is in error and `bctl_perr_en`=1, `s_claim` stays low two clocks after the phase. With `bctl_perr_en`=0 the phase is claimed as if the parity were good.
- R3: `s_claim` pulses high exactly two clocks after a secondary address phase whose `s_hit` was 1 (subject to R2), and never for a phase with `s_hit`=0.
- R4: `p_serr_n` goes low for one clock, two clocks after a secondary address phase, only when that phase is in error and both `cmd_serr_en` and `bctl_perr_en` are 1. The same event sets `stat[1]`.
- R5: `stat[2]` is set by any secondary address or read-data parity error, whatever the enable bits are.
- R6: `cfg_trdy` pulses high two clocks after every configuration-write data phase (`p_cfg_vld`), whether or not its parity is bad, so the write still completes.
- R7: `p_perr_n` goes low for one clock, two clocks after a configuration-write data phase in error, only when `cmd_perr_en`=1.
- R8: `stat[0]` is set by a configuration-write data parity error, whatever the enable bits are.
- R9: `s_perr_n` goes low for one clock, two clocks after a secondary read-data phase (`s_rd_vld`) in error, only when `bctl_perr_en`=1.
- R10: Two clocks after a secondary read-data phase, `p_fwd_vld` is high and `p_fwd_par` equals the `s_par` value sampled one clock after that phase, good or bad.
- R11: Status bits become visible one clock after their reaction pulse and remain set until a `stat_clr` bit at the same position is high at a clock edge. A set and a clear in the same cycle leave the bit set.
- R12: After reset, `s_claim`, `cfg_trdy` and `p_fwd_vld` are 0, all three active-low error outputs are 1, and `stat` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_perr_en | input | 1 | Primary parity-response enable (command word) |
| cmd_serr_en | input | 1 | Primary system-error enable (command word) |
| bctl_perr_en | input | 1 | Secondary parity-response enable (bridge control word) |
| p_ad | input | 32 | Primary address/data lines |
| p_cbe | input | 4 | Primary command/byte-enable lines |
| p_par | input | 1 | Primary parity, one clock after its phase |
| p_cfg_vld | input | 1 | Data phase of a Type 0 configuration write to the bridge |
| s_ad | input | 32 | Secondary address/data lines |
| s_cbe | input | 4 | Secondary command/byte-enable lines |
| s_par | input | 1 | Secondary parity, one clock after its phase |
| s_addr_vld | input | 1 | Secondary address phase |
| s_hit | input | 1 | The secondary address targets or crosses the bridge |
| s_rd_vld | input | 1 | Secondary data phase of a downstream read |
| stat_clr | input | 3 | Write-one-to-clear pulses for `stat` |
| s_claim | output | 1 | Claim (device-select) decision for a secondary address |
| cfg_trdy | output | 1 | Configuration write accepted and committed |
| p_perr_n | output | 1 | Primary data parity error pulse, active low |
| p_serr_n | output | 1 | Primary system error pulse, active low |
| s_perr_n | output | 1 | Secondary data parity error pulse, active low |
| p_fwd_vld | output | 1 | Forwarded read parity is valid |
| p_fwd_par | output | 1 | Read parity handed on to the primary side unchanged |
| stat | output | 3 | Sticky flags: [0] primary parity detected, [1] system error signaled, [2] secondary parity detected |

## Verification
The assertions check on every cycle that each pulse has a cause two clocks back: an error line is never low without the matching phase and enable, no claim appears without a hit, no claim coexists with a system-error pulse, the forwarded parity equals the sampled bit, and status bits never drop without a clear. Whether a pulse that should appear actually does appear cannot be shown this way. The exact enable combination that gates each reaction, the set-over-clear priority and the parity arithmetic itself come from the bench. It sweeps every enable setting against good and single-bit-corrupted phases on all three streams and compares each outcome cycle by cycle.

// File: rtl/pbr_par_pkg.sv
package pbr_par_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   // status flag positions (software decodes these)
   localparam int ST_P_DPE = 0;
   localparam int ST_P_SSE = 1;
   localparam int ST_S_DPE = 2;
   localparam int STAT_W   = 3;

   // phase stream indices
   localparam int SI_ADDR = 0;
   localparam int SI_RD   = 1;
   localparam int SI_CFG  = 2;
   localparam int N_STR   = 3;

   typedef struct packed {
      logic s_ape;   // secondary address parity error
      logic s_rde;   // secondary read data parity error
      logic p_cde;   // primary config write data parity error
      logic serr;    // system error to be signaled
   } perr_evt_t;
endpackage

// File: rtl/pbr_par_tree.sv
module pbr_par_tree #(
   parameter int DW    = 36,
   parameter int STYLE = 1    // 0: flat reduction, 1: per-lane tree
) (
   input  logic [DW-1:0] din,
   output logic          par
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int LANE  = 8;
   localparam int NLANE = (DW + LANE - 1) / LANE;
   localparam int PADW  = NLANE * LANE;

   generate
      if (STYLE == 0) begin : g_flat
         assign par = ^din;
      end else begin : g_tree
         logic [PADW-1:0]  padded;
         logic [NLANE-1:0] lane_par;
         assign padded = PADW'(din);
         for (genvar gl = 0; gl < NLANE; gl++) begin : g_lane
            assign lane_par[gl] = ^padded[gl*LANE +: LANE];
         end
         assign par = ^lane_par;
      end
   endgenerate
endmodule

// File: rtl/pbr_phase_chk.sv
module pbr_phase_chk #(
   parameter int AD_W      = 32,
   parameter int BE_W      = 4,
   parameter int PAR_STYLE = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            vld,
   input  logic [AD_W-1:0] ad,
   input  logic [BE_W-1:0] cbe,
   input  logic            par,
   input  logic            tag,
   output logic            done,
   output logic            err,
   output logic            tag_q
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int CW = AD_W + BE_W;

   logic exp_par;
   logic exp_q, pend_q, tag_p;

   pbr_par_tree #(.DW(CW), .STYLE(PAR_STYLE)) u_tree (
      .din ({ad, cbe}),
      .par (exp_par)
   );

   // stage 1: phase seen, expected parity held; stage 2: compare with PAR
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         exp_q  <= 1'b0;
         tag_p  <= 1'b0;
         done   <= 1'b0;
         err    <= 1'b0;
         tag_q  <= 1'b0;
      end else begin
         pend_q <= vld;
         exp_q  <= exp_par;
         tag_p  <= tag;
         done   <= pend_q;
         err    <= pend_q & (par ^ exp_q);
         tag_q  <= tag_p;
      end
   end
endmodule

// File: rtl/pbr_stat_regs.sv
module pbr_stat_regs #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] stat
);
   timeunit 1ns;
   timeprecision 1ps;

   always_ff @(posedge clk) begin
      if (!rst_n) stat <= '0;
      else        stat <= (stat & ~clr) | set;   // set has priority
   end
endmodule

// File: rtl/pbr_parity_guard.sv
module pbr_parity_guard
   import pbr_par_pkg::*;
#(
   parameter int AD_W      = 32,
   parameter int PAR_STYLE = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_perr_en,
   input  logic                cmd_serr_en,
   input  logic                bctl_perr_en,
   input  logic [AD_W-1:0]     p_ad,
   input  logic [AD_W/8-1:0]   p_cbe,
   input  logic                p_par,
   input  logic                p_cfg_vld,
   input  logic [AD_W-1:0]     s_ad,
   input  logic [AD_W/8-1:0]   s_cbe,
   input  logic                s_par,
   input  logic                s_addr_vld,
   input  logic                s_hit,
   input  logic                s_rd_vld,
   input  logic [STAT_W-1:0]   stat_clr,
   output logic                s_claim,
   output logic                cfg_trdy,
   output logic                p_perr_n,
   output logic                p_serr_n,
   output logic                s_perr_n,
   output logic                p_fwd_vld,
   output logic                p_fwd_par,
   output logic [STAT_W-1:0]   stat
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int BE_W = AD_W / 8;

   generate
      if (AD_W < 8 || (AD_W % 8) != 0) begin : g_bad_width
         $error("pbr_parity_guard: AD_W must be a nonzero multiple of 8");
      end
      if (PAR_STYLE < 0 || PAR_STYLE > 1) begin : g_bad_style
         $error("pbr_parity_guard: PAR_STYLE must be 0 or 1");
      end
   endgenerate

   logic [AD_W-1:0] st_ad  [N_STR];
   logic [BE_W-1:0] st_be  [N_STR];
   logic            st_par [N_STR];
   logic            st_vld [N_STR];
   logic            st_tag [N_STR];
   logic            st_done[N_STR];
   logic            st_err [N_STR];
   logic            st_tagq[N_STR];

   // stream inputs: secondary address, secondary read data, primary cfg write
   assign st_ad[SI_ADDR]  = s_ad;
   assign st_be[SI_ADDR]  = s_cbe;
   assign st_par[SI_ADDR] = s_par;
   assign st_vld[SI_ADDR] = s_addr_vld;
   assign st_tag[SI_ADDR] = s_hit;

   assign st_ad[SI_RD]    = s_ad;
   assign st_be[SI_RD]    = s_cbe;
   assign st_par[SI_RD]   = s_par;
   assign st_vld[SI_RD]   = s_rd_vld;
   assign st_tag[SI_RD]   = 1'b0;

   assign st_ad[SI_CFG]   = p_ad;
   assign st_be[SI_CFG]   = p_cbe;
   assign st_par[SI_CFG]  = p_par;
   assign st_vld[SI_CFG]  = p_cfg_vld;
   assign st_tag[SI_CFG]  = 1'b0;

   for (genvar gs = 0; gs < N_STR; gs++) begin : g_str
      pbr_phase_chk #(
         .AD_W      (AD_W),
         .BE_W      (BE_W),
         .PAR_STYLE (PAR_STYLE)
      ) u_chk (
         .clk   (clk),
         .rst_n (rst_n),
         .vld   (st_vld[gs]),
         .ad    (st_ad[gs]),
         .cbe   (st_be[gs]),
         .par   (st_par[gs]),
         .tag   (st_tag[gs]),
         .done  (st_done[gs]),
         .err   (st_err[gs]),
         .tag_q (st_tagq[gs])
      );
   end

   logic unused_tags;
   assign unused_tags = st_tagq[SI_RD] ^ st_tagq[SI_CFG];

   // read parity is carried across as received, one stage behind its sample
   logic fwd_par_q;
   always_ff @(posedge clk) begin
      if (!rst_n) fwd_par_q <= 1'b0;
      else        fwd_par_q <= s_par;
   end

   perr_evt_t evt;
   always_comb begin
      evt.s_ape = st_err[SI_ADDR];
      evt.s_rde = st_err[SI_RD];
      evt.p_cde = st_err[SI_CFG];
      evt.serr  = st_err[SI_ADDR] & cmd_serr_en & bctl_perr_en;
   end

   assign s_claim   = st_done[SI_ADDR] & st_tagq[SI_ADDR] & ~(evt.s_ape & bctl_perr_en);
   assign cfg_trdy  = st_done[SI_CFG];
   assign p_perr_n  = ~(evt.p_cde & cmd_perr_en);
   assign s_perr_n  = ~(evt.s_rde & bctl_perr_en);
   assign p_serr_n  = ~evt.serr;
   assign p_fwd_vld = st_done[SI_RD];
   assign p_fwd_par = fwd_par_q;

   logic [STAT_W-1:0] stat_set;
   always_comb begin
      stat_set           = '0;
      stat_set[ST_P_DPE] = evt.p_cde;
      stat_set[ST_P_SSE] = evt.serr;
      stat_set[ST_S_DPE] = evt.s_ape | evt.s_rde;
   end

   pbr_stat_regs #(.W(STAT_W)) u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (stat_set),
      .clr   (stat_clr),
      .stat  (stat)
   );
endmodule

// File: rtl/pbr_parity_guard_chk.sv
module pbr_parity_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_perr_en,
   input logic       cmd_serr_en,
   input logic       bctl_perr_en,
   input logic       p_cfg_vld,
   input logic       s_par,
   input logic       s_addr_vld,
   input logic       s_hit,
   input logic       s_rd_vld,
   input logic [2:0] stat_clr,
   input logic       s_claim,
   input logic       cfg_trdy,
   input logic       p_perr_n,
   input logic       p_serr_n,
   input logic       s_perr_n,
   input logic       p_fwd_vld,
   input logic       p_fwd_par,
   input logic [2:0] stat
);
   timeunit 1ns;
   timeprecision 1ps;

   assert_claim_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
      s_claim |-> ($past(s_addr_vld, 2) && $past(s_hit, 2)));

   assert_claim_supp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !p_serr_n |-> !s_claim);

   assert_serr_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !p_serr_n |-> (cmd_serr_en && bctl_perr_en && $past(s_addr_vld, 2)));

   assert_serr_stat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !p_serr_n |=> stat[1]);

   assert_sperr_stat_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !s_perr_n |=> stat[2]);

   assert_trdy_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_trdy |-> $past(p_cfg_vld, 2));

   assert_pperr_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !p_perr_n |-> (cmd_perr_en && cfg_trdy && $past(p_cfg_vld, 2)));

   assert_pperr_stat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !p_perr_n |=> stat[0]);

   assert_sperr_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !s_perr_n |-> (bctl_perr_en && $past(s_rd_vld, 2)));

   assert_fwd_par_R10: assert property (@(posedge clk) disable iff (!rst_n)
      p_fwd_vld |-> ($past(s_rd_vld, 2) && (p_fwd_par == $past(s_par, 1))));

   assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(stat) & ~$past(stat_clr) & ~stat) == 3'b000));
endmodule

bind pbr_parity_guard pbr_parity_guard_chk u_guard_chk (.*);

// File: tb/tb_pbr_parity_guard.sv
module tb_pbr_parity_guard;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_perr_en = 1'b0, cmd_serr_en = 1'b0, bctl_perr_en = 1'b0;
   logic [31:0] p_ad = '0, s_ad = '0;
   logic [3:0]  p_cbe = '0, s_cbe = '0;
   logic        p_par = 1'b0, s_par = 1'b0;
   logic        p_cfg_vld = 1'b0, s_addr_vld = 1'b0, s_hit = 1'b0, s_rd_vld = 1'b0;
   logic [2:0]  stat_clr = '0;
   logic        s_claim, cfg_trdy, p_perr_n, p_serr_n, s_perr_n, p_fwd_vld, p_fwd_par;
   logic [2:0]  stat;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   pbr_parity_guard dut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // kind: 0 secondary address, 1 secondary read data, 2 primary cfg write
   task automatic run_phase(input int kind, input logic [2:0] en, input logic [31:0] ad,
                            input logic [3:0] be, input logic hit, input logic bad, input int k);
      logic good_par, drv_par;
      logic [31:0] ad_drv;
      logic exp_claim, exp_serr, exp_pperr, exp_sperr;
      logic [2:0] exp_stat;
      good_par = ($countones({ad, be}) % 2) == 1;   // makes the 37-bit total even (R1)
      ad_drv   = bad ? (ad ^ (32'd1 << k)) : ad;    // single-bit flip
      drv_par  = good_par;
      @(negedge clk);
      {cmd_perr_en, cmd_serr_en, bctl_perr_en} = {en[0], en[1], en[2]};
      case (kind)
         0: begin s_ad = ad_drv; s_cbe = be; s_addr_vld = 1'b1; s_hit = hit; end
         1: begin s_ad = ad_drv; s_cbe = be; s_rd_vld = 1'b1; end
         default: begin p_ad = ad_drv; p_cbe = be; p_cfg_vld = 1'b1; end
      endcase
      @(negedge clk);
      s_addr_vld = 1'b0; s_rd_vld = 1'b0; p_cfg_vld = 1'b0; s_hit = 1'b0;
      s_ad = ~s_ad; p_ad = ~p_ad;
      if (kind == 2) p_par = drv_par; else s_par = drv_par;
      @(negedge clk);   // two clocks after the phase
      exp_claim = (kind == 0) && hit && !(bad && en[2]);
      exp_serr  = (kind == 0) && bad && en[1] && en[2];
      exp_pperr = (kind == 2) && bad && en[0];
      exp_sperr = (kind == 1) && bad && en[2];
      chk("R2/R3 claim", 32'(s_claim), 32'(exp_claim));
      chk("R4 serr", 32'(p_serr_n), 32'(!exp_serr));
      chk("R6 trdy", 32'(cfg_trdy), 32'(kind == 2));
      chk("R7 pperr", 32'(p_perr_n), 32'(!exp_pperr));
      chk("R9 sperr", 32'(s_perr_n), 32'(!exp_sperr));
      chk("R10 fwd_vld", 32'(p_fwd_vld), 32'(kind == 1));
      if (kind == 1) chk("R10 fwd_par", 32'(p_fwd_par), 32'(drv_par));
      chk("R11 stat not yet", 32'(stat), 32'd0);
      s_par = ~s_par; p_par = ~p_par;
      @(negedge clk);
      exp_stat    = '0;
      exp_stat[0] = (kind == 2) && bad;
      exp_stat[1] = exp_serr;
      exp_stat[2] = (kind != 2) && bad;
      chk("R5/R8 stat", 32'(stat), 32'(exp_stat));
      @(negedge clk);
      chk("R11 sticky", 32'(stat), 32'(exp_stat));
      stat_clr = 3'b111;
      @(negedge clk);
      stat_clr = 3'b000;
      chk("R11 w1c", 32'(stat), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R12: idle outputs while and right after reset
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 claim", 32'(s_claim), 32'd0);
      chk("R12 trdy", 32'(cfg_trdy), 32'd0);
      chk("R12 fwd", 32'(p_fwd_vld), 32'd0);
      chk("R12 errs", 32'({p_perr_n, p_serr_n, s_perr_n}), 32'h7);
      chk("R12 stat", 32'(stat), 32'd0);

      for (int kind = 0; kind < 3; kind++)
         for (int en = 0; en < 8; en++)
            for (int bad = 0; bad < 2; bad++)
               for (int pat = 0; pat < 2; pat++)
                  run_phase(kind, 3'(en), 32'h1234_5679 * 32'(en + 1) + 32'(pat * 32'h0F0F_0001),
                            4'(en + pat * 5), pat[0] ^ 1'b1, bad[0], (en * 5 + pat * 11 + kind) % 32);

      // R11: a set and a clear in the same cycle leave the bit set
      @(negedge clk);
      cmd_perr_en = 1'b0;
      p_ad = 32'hA5A5_0003; p_cbe = 4'h6; p_cfg_vld = 1'b1;
      @(negedge clk);
      p_cfg_vld = 1'b0;
      p_par = ~(($countones({32'hA5A5_0003, 4'h6}) % 2) == 1);
      @(negedge clk);
      chk("R8 no perr when disabled", 32'(p_perr_n), 32'd1);
      stat_clr = 3'b001;
      @(negedge clk);
      stat_clr = 3'b000;
      chk("R11 set wins", 32'(stat), 32'd1);
      stat_clr = 3'b001;
      @(negedge clk);
      stat_clr = 3'b000;
      chk("R11 clear", 32'(stat), 32'd0);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule